// File: doc/BRIEF.md
# Conditional Branch Resolver with Interlock

This block decides the direction of conditional branches that test one bit of the condition register. When a branch descriptor arrives, the block looks up the pending-writer scoreboard for the tested bit. If no in-flight instruction will still write that bit, the branch is settled in the same cycle from the live condition-register value. If a writer is still in flight, the branch is parked as unresolved. Its direction comes from a static guess, fetch is steered along the guessed path, and the block keeps watching the scoreboard.

Once the scoreboard shows that the tested bit is no longer pending, the block compares the real outcome with the guess. A correct guess completes the branch quietly. A wrong guess raises a flush that purges the guessed-path instructions and redirects fetch to the other path, whose address was saved when the guess was made. Only one branch may be parked at a time.

The condition-register input is taken to already hold the written value in the same cycle that a bit's pending flag drops.

Top module: `cbr_resolver`

## Requirements
- R1: After reset, redirValid, flush, resolved, resolvedTaken, brStall and unresolved are all 0.
- R2: A presented branch whose tested bit is not pending is resolved in the same cycle, unless a held branch clears in that cycle. The outcome is taken when crValue[brBit] equals brSense. resolved pulses, resolvedTaken gives the outcome, and redirValid is raised with the branch target only when the outcome is taken.
- R3: When no branch is held, a presented branch whose tested bit is pending is guessed taken when brHint XOR brDisp[AW-1] is 1. A taken guess raises redirValid to the target in the same cycle. resolved stays 0 and unresolved is 1 from the next cycle.
- R4: While the held branch's tested bit remains pending, unresolved stays 1 and no resolution or flush is reported for it.
- R5: In the first cycle that the held bit is not pending, if the outcome matches the guess, resolved pulses with resolvedTaken equal to the guess. No flush and no redirect are raised, and unresolved is 0 from the next cycle.
- R6: On a mismatch, flush and redirValid are raised together with resolved, and resolvedTaken gives the real outcome. redirAddr is the fall-through address if the guess was taken, or the target if the guess was not taken. unresolved is 0 from the next cycle.
- R7: Every redirect address has its two least significant bits at 0.
- R8: While a branch is held, a new branch whose tested bit is pending is refused with brStall. A new branch whose bit is not pending resolves as in R2.
- R9: In a cycle where the held branch clears with a matching guess, any presented branch gets brStall. In a cycle with a flush, a presented branch gets no stall and produces no resolution of its own.
- R10: The target is brPc + brDisp and the fall-through is brPc + 4, both taken modulo 2^AW before the low two bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | Branch descriptor present this cycle |
| brPc | input | AW | Address of the branch |
| brDisp | input | AW | Signed displacement to the target |
| brBit | input | clog2(CRW) | Index of the tested condition bit |
| brSense | input | 1 | Bit value that makes the branch taken |
| brHint | input | 1 | Static hint, inverts the sign-based guess |
| crValue | input | CRW | Current condition register |
| crPending | input | CRW | Per-bit flag: an in-flight writer exists |
| redirValid | output | 1 | Fetch redirect this cycle |
| redirAddr | output | AW | Redirect address (0 when no redirect) |
| flush | output | 1 | Purge guessed-path instructions |
| resolved | output | 1 | A branch's direction is final this cycle |
| resolvedTaken | output | 1 | Final direction (0 when resolved is 0) |
| brStall | output | 1 | Presented branch not accepted; present again |
| unresolved | output | 1 | A guessed branch is held |

## Verification
The properties assume that crPending and crValue are valid in every cycle. They also assume that descriptor fields matter only while brValid is high, and that a held bit's value can be read in the cycle its pending flag falls. The stimulus redraws crValue every cycle and flips pending flags with a fixed chance on each cycle. It draws tested bits from a small index range, so that held bits clear after a few cycles and new branches often hit the held bit or another busy bit. Directed sequences first place a branch in each case: clear, flush, stall and shadow.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic capture;      // load the held-branch slot
    logic redirTarget;  // drive target of the presented branch
    logic redirAlt;     // drive saved alternate-path address
  } cbrStrobes_t;
endpackage

// File: rtl/cbr_dpath.sv
module cbr_dpath
  import cbr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CRW = 32,
  parameter int BW  = $clog2(CRW)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [AW-1:0]  brPc,
  input  logic [AW-1:0]  brDisp,
  input  logic [BW-1:0]  brBit,
  input  logic           brSense,
  input  logic           brHint,
  input  logic [CRW-1:0] crValue,
  input  logic [CRW-1:0] crPending,
  input  cbrStrobes_t    strobe,
  output logic           newPend,
  output logic           newTaken,
  output logic           newPred,
  output logic           heldPend,
  output logic           heldTaken,
  output logic           heldPred,
  output logic [AW-1:0]  redirAddr
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
  localparam logic [AW-1:0] STEP       = AW'(4);

  logic [BW-1:0] heldBit;
  logic          heldSense;
  logic [AW-1:0] altAddr;
  logic [AW-1:0] targetAddr;
  logic [AW-1:0] fallAddr;

  assign targetAddr = (brPc + brDisp) & ALIGN_MASK;
  assign fallAddr   = (brPc + STEP) & ALIGN_MASK;

  assign newPend  = crPending[brBit];
  assign newTaken = (crValue[brBit] == brSense);
  assign newPred  = brHint ^ brDisp[AW-1];

  assign heldPend  = crPending[heldBit];
  assign heldTaken = (crValue[heldBit] == heldSense);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldBit   <= '0;
      heldSense <= 1'b0;
      heldPred  <= 1'b0;
      altAddr   <= '0;
    end else if (strobe.capture) begin
      heldBit   <= brBit;
      heldSense <= brSense;
      heldPred  <= newPred;
      altAddr   <= newPred ? fallAddr : targetAddr;
    end
  end

  always_comb begin
    if (strobe.redirAlt)         redirAddr = altAddr;
    else if (strobe.redirTarget) redirAddr = targetAddr;
    else                         redirAddr = '0;
  end
endmodule

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        brValid,
  input  logic        newPend,
  input  logic        newTaken,
  input  logic        newPred,
  input  logic        heldPend,
  input  logic        heldTaken,
  input  logic        heldPred,
  output cbrStrobes_t strobe,
  output logic        redirValid,
  output logic        flush,
  output logic        resolved,
  output logic        resolvedTaken,
  output logic        brStall,
  output logic        unresolved
);
  logic busy;
  logic clearNow;
  logic mispredict;
  logic accept;

  assign unresolved = busy;
  assign clearNow   = busy & ~heldPend;
  assign mispredict = clearNow & (heldTaken != heldPred);
  // one resolution per cycle; one held branch at a time
  assign accept     = brValid & ~clearNow & ~(busy & newPend);
  assign brStall    = brValid & ~mispredict & ~accept;

  always_comb begin
    strobe        = '0;
    redirValid    = 1'b0;
    flush         = 1'b0;
    resolved      = 1'b0;
    resolvedTaken = 1'b0;
    if (mispredict) begin
      flush           = 1'b1;
      redirValid      = 1'b1;
      strobe.redirAlt = 1'b1;
      resolved        = 1'b1;
      resolvedTaken   = heldTaken;
    end else if (clearNow) begin
      resolved      = 1'b1;
      resolvedTaken = heldPred;
    end else if (accept && !newPend) begin
      resolved           = 1'b1;
      resolvedTaken      = newTaken;
      redirValid         = newTaken;
      strobe.redirTarget = newTaken;
    end else if (accept) begin
      strobe.capture     = 1'b1;
      redirValid         = newPred;
      strobe.redirTarget = newPred;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               busy <= 1'b0;
    else if (clearNow)       busy <= 1'b0;
    else if (strobe.capture) busy <= 1'b1;
  end
endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
  import cbr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CRW = 32,
  localparam int BW = $clog2(CRW)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           brValid,
  input  logic [AW-1:0]  brPc,
  input  logic [AW-1:0]  brDisp,
  input  logic [BW-1:0]  brBit,
  input  logic           brSense,
  input  logic           brHint,
  input  logic [CRW-1:0] crValue,
  input  logic [CRW-1:0] crPending,
  output logic           redirValid,
  output logic [AW-1:0]  redirAddr,
  output logic           flush,
  output logic           resolved,
  output logic           resolvedTaken,
  output logic           brStall,
  output logic           unresolved
);
  cbrStrobes_t strobe;
  logic newPend, newTaken, newPred, heldPend, heldTaken, heldPred;

  cbr_dpath #(.AW(AW), .CRW(CRW), .BW(BW)) u_dpath (
    .clk(clk), .rstN(rstN), .brPc(brPc), .brDisp(brDisp), .brBit(brBit),
    .brSense(brSense), .brHint(brHint), .crValue(crValue),
    .crPending(crPending), .strobe(strobe), .newPend(newPend),
    .newTaken(newTaken), .newPred(newPred), .heldPend(heldPend),
    .heldTaken(heldTaken), .heldPred(heldPred), .redirAddr(redirAddr)
  );

  cbr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .brValid(brValid), .newPend(newPend),
    .newTaken(newTaken), .newPred(newPred), .heldPend(heldPend),
    .heldTaken(heldTaken), .heldPred(heldPred), .strobe(strobe),
    .redirValid(redirValid), .flush(flush), .resolved(resolved),
    .resolvedTaken(resolvedTaken), .brStall(brStall),
    .unresolved(unresolved)
  );
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int AW  = 32,
  parameter int CRW = 32,
  parameter int BW  = $clog2(CRW)
) (
  input logic           clk,
  input logic           rstN,
  input logic           brValid,
  input logic [BW-1:0]  brBit,
  input logic [CRW-1:0] crPending,
  input logic           redirValid,
  input logic [1:0]     redirLow,
  input logic           flush,
  input logic           resolved,
  input logic           brStall,
  input logic           unresolved
);
  p_immediate_r2: assert property (@(posedge clk) disable iff (!rstN)
    brValid && !crPending[brBit] && !unresolved |-> resolved && !brStall && !flush);

  p_enter_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    brValid && crPending[brBit] && !unresolved |=> unresolved);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    unresolved && !resolved |=> unresolved);

  p_flush_redir_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> redirValid && unresolved && resolved);

  p_flush_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !unresolved);

  p_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> redirLow == 2'b00);

  p_single_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    unresolved && brValid && crPending[brBit] && !flush |-> brStall);

  p_flush_nostall_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !brStall);
endmodule

bind cbr_resolver cbr_checker #(.AW(AW), .CRW(CRW), .BW(BW)) u_chk (
  .clk(clk), .rstN(rstN), .brValid(brValid), .brBit(brBit),
  .crPending(crPending), .redirValid(redirValid), .redirLow(redirAddr[1:0]),
  .flush(flush), .resolved(resolved), .brStall(brStall),
  .unresolved(unresolved)
);

// File: tb/tb_cbr_resolver.sv
module tb_cbr_resolver;
  localparam int AW  = 32;
  localparam int CRW = 32;
  localparam int BW  = $clog2(CRW);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic brValid = 1'b0;
  logic [AW-1:0] brPc = '0, brDisp = '0;
  logic [BW-1:0] brBit = '0;
  logic brSense = 1'b0, brHint = 1'b0;
  logic [CRW-1:0] crValue = '0, crPending = '0;
  logic redirValid, flush, resolved, resolvedTaken, brStall, unresolved;
  logic [AW-1:0] redirAddr;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit mBusy = 1'b0;
  int mBit = 0;
  bit mSense = 1'b0, mPred = 1'b0;
  logic [AW-1:0] mAlt = '0;

  always #10 clk = ~clk;

  cbr_resolver #(.AW(AW), .CRW(CRW)) dut (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brPc(brPc), .brDisp(brDisp),
    .brBit(brBit), .brSense(brSense), .brHint(brHint), .crValue(crValue),
    .crPending(crPending), .redirValid(redirValid), .redirAddr(redirAddr),
    .flush(flush), .resolved(resolved), .resolvedTaken(resolvedTaken),
    .brStall(brStall), .unresolved(unresolved)
  );

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // drives one cycle at negedge, compares mid-low phase, advances model at posedge
  task automatic step(bit v, logic [AW-1:0] pc, logic [AW-1:0] disp, int bitIdx,
                      bit sense, bit hint, logic [CRW-1:0] crv, logic [CRW-1:0] pend);
    bit clr, mis, nPend, nTaken, nPred, ht;
    bit eRv, eFl, eRes, eRt, eSt, nextBusy, cap;
    logic [AW-1:0] eAddr, tgt, fall;
    string tag;
    brValid = v; brPc = pc; brDisp = disp; brBit = BW'(bitIdx);
    brSense = sense; brHint = hint; crValue = crv; crPending = pend;
    #5;
    clr = mBusy && !pend[mBit];
    ht = (crv[mBit] == mSense);
    mis = clr && (ht != mPred);
    nPend = pend[bitIdx];
    nTaken = (crv[bitIdx] == sense);
    nPred = hint ^ disp[AW-1];
    tgt = (pc + disp) & ~AW'(3);
    fall = (pc + 32'd4) & ~AW'(3);
    eRv = 0; eAddr = '0; eFl = 0; eRes = 0; eRt = 0; eSt = 0; cap = 0;
    nextBusy = mBusy;
    tag = mBusy ? "R4" : "R1";
    if (mis) begin
      tag = v ? "R6/R9" : "R6";
      eFl = 1; eRv = 1; eAddr = mAlt; eRes = 1; eRt = ht; nextBusy = 0;
    end else if (clr) begin
      tag = v ? "R5/R9" : "R5";
      eRes = 1; eRt = mPred; eSt = v; nextBusy = 0;
    end else if (v && mBusy && nPend) begin
      tag = "R8"; eSt = 1;
    end else if (v && !nPend) begin
      tag = mBusy ? "R8" : "R2/R10";
      eRes = 1; eRt = nTaken; eRv = nTaken; eAddr = nTaken ? tgt : '0;
    end else if (v) begin
      tag = "R3/R10";
      eRv = nPred; eAddr = nPred ? tgt : '0; cap = 1; nextBusy = 1;
    end
    vectors++;
    chk(tag, "redirValid", AW'(redirValid), AW'(eRv));
    chk(tag, "redirAddr", redirAddr, eAddr);
    chk(tag, "flush", AW'(flush), AW'(eFl));
    chk(tag, "resolved", AW'(resolved), AW'(eRes));
    chk(tag, "resolvedTaken", AW'(resolvedTaken), AW'(eRt));
    chk(tag, "brStall", AW'(brStall), AW'(eSt));
    chk(tag, "unresolved", AW'(unresolved), AW'(mBusy));
    if (redirValid && redirAddr[1:0] != 2'b00) begin
      fails++;
      $display("FAIL R7 redirAddr low bits actual=%b expected=00", redirAddr[1:0]);
    end
    @(posedge clk);
    if (cap) begin
      mBit = bitIdx; mSense = sense; mPred = nPred; mAlt = nPred ? fall : tgt;
    end
    mBusy = nextBusy;
    @(negedge clk);
  endtask

  task automatic idle(logic [CRW-1:0] crv, logic [CRW-1:0] pend);
    step(0, '0, '0, 0, 0, 0, crv, pend);
  endtask

  initial begin
    logic [CRW-1:0] pendR;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    idle('0, '0);
    // R2: immediate, taken and not taken, misaligned inputs (R7, R10)
    step(1, 32'h0000_1003, 32'h0000_0101, 3, 1, 0, 32'h0000_0008, '0);
    step(1, 32'h0000_2000, 32'h0000_0040, 3, 1, 0, 32'h0000_0000, '0);
    step(1, 32'hFFFF_FFFE, 32'h0000_0007, 5, 0, 1, 32'h0000_0000, '0);
    // R3/R4/R5: backward branch guessed taken, bit 2 pending, clears matching
    step(1, 32'h0000_3000, 32'hFFFF_FF00, 2, 1, 0, '0, 32'h4);
    idle('0, 32'h4);
    idle('0, 32'h4);
    idle(32'h4, '0);
    // R6: forward branch guessed not taken, turns out taken -> target
    step(1, 32'h0000_4000, 32'h0000_0080, 1, 1, 0, '0, 32'h2);
    idle('0, 32'h2);
    idle(32'h2, '0);
    // R6: guessed taken (hint flips forward), turns out not taken -> fall-through
    step(1, 32'h0000_5002, 32'h0000_0010, 6, 1, 1, '0, 32'h40);
    idle('0, '0);
    // R8: held branch, new pending branch stalls, new clear branch resolves
    step(1, 32'h0000_6000, 32'hFFFF_FFF0, 0, 0, 0, '0, 32'h3);
    step(1, 32'h0000_7000, 32'h0000_0020, 1, 1, 0, '0, 32'h3);
    step(1, 32'h0000_7100, 32'h0000_0024, 4, 0, 0, '0, 32'h3);
    // R9: held clears matching with a branch presented -> stall
    step(1, 32'h0000_7200, 32'h0000_0028, 4, 0, 0, '0, '0);
    // R9: held mispredict with a branch presented -> dropped
    step(1, 32'h0000_8000, 32'hFFFF_FFF0, 0, 1, 0, '0, 32'h1);
    step(1, 32'h0000_8100, 32'h0000_0030, 4, 0, 0, '0, '0);
    idle('0, '0);
    // random traffic
    pendR = '0;
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 8; b++) if (($urandom % 4) == 0) pendR[b] = ~pendR[b];
      step(($urandom % 3) != 0, $urandom, $urandom, int'($urandom % 8),
           $urandom % 2, $urandom % 2, $urandom, pendR);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule